// File: doc/BRIEF.md
# Start Trigger Select and Capture

This block picks one start trigger out of a set of candidate sources: a software pulse strobe, ten external trigger pins, seven bus trigger lines and the output of general-purpose counter 0. A 5-bit select code chooses the source. Several codes are unused, and one is reserved to hold the trigger low. The chosen trigger can be passed through a synchronizer clocked by the scan clock, or it can go around the synchronizer when it already arrives in step with that clock or when this unit follows another device's trigger.

A rising edge of the chosen trigger counts as a valid start only while the companion scan counter reports that it is both armed and in its first wait state. A valid start shows as a single-cycle pulse and sets a sticky status flag. The flag stays set until software writes an acknowledge. An enable bit gates the flag onto an interrupt request. The scan counter is not part of this block; its armed and waiting indications are inputs.

All logic runs on the scan clock `clk` and uses an asynchronous active-low reset.

Top module: `stsel_top`

## Requirements
- R1: After reset the status flag and interrupt are 0, the sync and interrupt enables are 0, and the select code is 31, so `trig_sel` is 0 whatever the sources do.
- R2: Select code 0 picks `sw_pulse`, codes 1..10 pick `ext_pin[0..9]`, codes 11..17 pick `bus_trig[0..6]`, and code 18 picks `gp_cnt_out`.
- R3: Select codes 19 through 31 drive the selected trigger to 0.
- R4: `cfg_sel`, `cfg_sync_en` and `cfg_irq_en` load on a clock edge where `cfg_wr` is 1, and are held unchanged on any other edge.
- R5: With synchronization on, a rise of the selected source before edge k makes `trig_sel` go high after edge k+1. `trig_valid` is high for exactly the one cycle between edges k+1 and k+2.
- R6: With synchronization off, `trig_sel` follows the selected source with no register delay. `trig_valid` is high in the same cycle as the source's rise.
- R7: Select code 0 always uses the synchronizer, even when `cfg_sync_en` is 0.
- R8: A trigger edge gives `trig_valid` only while both `cnt_armed` and `cnt_waiting` are 1. Otherwise it leaves `trig_valid` at 0 and `status` unchanged.
- R9: `status` becomes 1 on the clock edge that ends a `trig_valid` cycle, and stays 1 after the trigger goes away.
- R10: An `ack` at a clock edge clears `status` when no valid trigger occurs in that cycle.
- R11: When `ack` and `trig_valid` occur in the same cycle, `status` stays (or becomes) 1.
- R12: `irq` is 1 exactly when `status` and the stored interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_pulse | input | 1 | Software start strobe (code 0) |
| ext_pin | input | 10 | External trigger pins (codes 1..10) |
| bus_trig | input | 7 | Bus trigger lines (codes 11..17) |
| gp_cnt_out | input | 1 | General-purpose counter 0 output (code 18) |
| cfg_wr | input | 1 | Write strobe for the configuration fields |
| cfg_sel | input | 5 | Source select code |
| cfg_sync_en | input | 1 | Synchronizer enable |
| cfg_irq_en | input | 1 | Interrupt enable |
| ack | input | 1 | Clears the status flag |
| cnt_armed | input | 1 | Scan counter is armed |
| cnt_waiting | input | 1 | Scan counter is in its first wait state |
| trig_sel | output | 1 | Selected trigger, after the synchronizer when it is used |
| trig_valid | output | 1 | One-cycle pulse for an accepted start |
| status | output | 1 | Sticky start-received flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps all 32 select codes against each of the 19 sources driven one-hot. A decoder that is off by one at a group boundary (codes 10/11 or 17/18) shows up there, as does one that lets an unused code reach a source.

Two timing cases are counted cycle by cycle:
- With synchronization on, a synchronizer that is a stage short or long moves the pulse to the wrong cycle.
- With synchronization off, a pulse that lags one cycle behind the source is caught.

Code 0 with the sync field cleared is run to catch a bypass that ignores the forced-sync rule. The three gating combinations of armed and waiting are tried to catch a status flag that sets without both. A simultaneous acknowledge and trigger exposes a clear that wrongly has priority over the set.

// File: rtl/stsel_pkg.sv
package stsel_pkg;
   localparam int unsigned SEL_W    = 5;
   localparam int unsigned SEL_LOW  = (1 << SEL_W) - 1;

   typedef struct packed {
      logic [SEL_W-1:0] sel;
      logic             sync_en;
      logic             irq_en;
   } stsel_cfg_t;

   localparam stsel_cfg_t CFG_RESET = '{sel: SEL_W'(SEL_LOW), sync_en: 1'b0, irq_en: 1'b0};
endpackage

// File: rtl/stsel_cfg.sv
module stsel_cfg
   import stsel_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [SEL_W-1:0] sel_in,
   input  logic             sync_in,
   input  logic             irq_in,
   output logic [SEL_W-1:0] sel_o,
   output logic             bypass_o,
   output logic             irq_en_o
);
   stsel_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_RESET;
      end else if (wr) begin
         cfg_q <= '{sel: sel_in, sync_en: sync_in, irq_en: irq_in};
      end
   end

   assign sel_o    = cfg_q.sel;
   assign irq_en_o = cfg_q.irq_en;
   // the software strobe source is never allowed around the synchronizer
   assign bypass_o = ~(cfg_q.sync_en | (cfg_q.sel == '0));

   // R4
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(cfg_q));
endmodule

// File: rtl/stsel_mux.sv
module stsel_mux
   import stsel_pkg::*;
#(
   parameter int unsigned NUM_EXT = 10,
   parameter int unsigned NUM_BUS = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SEL_W-1:0]   sel,
   input  logic               sw_pulse,
   input  logic [NUM_EXT-1:0] ext_pin,
   input  logic [NUM_BUS-1:0] bus_trig,
   input  logic               gp_cnt_out,
   output logic               trig_o
);
   localparam int unsigned NUM_SRC = NUM_EXT + NUM_BUS + 2;

   if (NUM_EXT < 1 || NUM_BUS < 1) begin : g_bad_count
      $error("stsel_mux: each source group needs at least one line");
   end
   if (NUM_SRC > SEL_LOW) begin : g_bad_space
      $error("stsel_mux: sources collide with the forced-low code");
   end

   logic [NUM_SRC-1:0] src_vec;
   logic [NUM_SRC-1:0] hit;

   assign src_vec = {gp_cnt_out, bus_trig, ext_pin, sw_pulse};

   for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_dec
      assign hit[gi] = (sel == SEL_W'(gi)) & src_vec[gi];
   end

   assign trig_o = |hit;

   // R3
   unused_code_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(sel) >= NUM_SRC) |-> !trig_o);
endmodule

// File: rtl/stsel_sync.sv
module stsel_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic bypass,
   output logic lvl_o,
   output logic edge_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("stsel_sync: at least two synchronizer stages are required");
   end

   logic [STAGES-1:0] chain;
   logic              sync_prev;
   logic              raw_prev;
   logic              sync_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain     <= '0;
         sync_prev <= 1'b0;
         raw_prev  <= 1'b0;
      end else begin
         chain     <= {chain[STAGES-2:0], din};
         sync_prev <= chain[STAGES-1];
         raw_prev  <= din;
      end
   end

   assign sync_edge = chain[STAGES-1] & ~sync_prev;
   assign lvl_o     = bypass ? din : chain[STAGES-1];
   assign edge_o    = bypass ? (din & ~raw_prev) : sync_edge;

   // R5
   sync_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_edge |=> !sync_edge);
endmodule

// File: rtl/stsel_capture.sv
module stsel_capture (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_edge,
   input  logic armed,
   input  logic waiting,
   input  logic ack,
   input  logic irq_en,
   output logic valid_o,
   output logic status_o,
   output logic irq_o
);
   logic status_q;

   assign valid_o = trig_edge & armed & waiting;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= 1'b0;
      end else if (valid_o) begin
         status_q <= 1'b1;
      end else if (ack) begin
         status_q <= 1'b0;
      end
   end

   assign status_o = status_q;
   assign irq_o    = status_q & irq_en;

   // R9
   status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> status_q);
   // R10
   status_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !valid_o) |=> !status_q);
   // R9
   status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack && !valid_o) |=> $stable(status_q));
endmodule

// File: rtl/stsel_top.sv
module stsel_top
   import stsel_pkg::*;
#(
   parameter int unsigned NUM_EXT     = 10,
   parameter int unsigned NUM_BUS     = 7,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sw_pulse,
   input  logic [NUM_EXT-1:0] ext_pin,
   input  logic [NUM_BUS-1:0] bus_trig,
   input  logic               gp_cnt_out,
   input  logic               cfg_wr,
   input  logic [SEL_W-1:0]   cfg_sel,
   input  logic               cfg_sync_en,
   input  logic               cfg_irq_en,
   input  logic               ack,
   input  logic               cnt_armed,
   input  logic               cnt_waiting,
   output logic               trig_sel,
   output logic               trig_valid,
   output logic               status,
   output logic               irq
);
   logic [SEL_W-1:0] sel_q;
   logic             bypass;
   logic             irq_en_q;
   logic             mux_out;
   logic             trig_edge;

   stsel_cfg u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (cfg_wr),
      .sel_in   (cfg_sel),
      .sync_in  (cfg_sync_en),
      .irq_in   (cfg_irq_en),
      .sel_o    (sel_q),
      .bypass_o (bypass),
      .irq_en_o (irq_en_q)
   );

   stsel_mux #(.NUM_EXT(NUM_EXT), .NUM_BUS(NUM_BUS)) u_mux (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (sel_q),
      .sw_pulse   (sw_pulse),
      .ext_pin    (ext_pin),
      .bus_trig   (bus_trig),
      .gp_cnt_out (gp_cnt_out),
      .trig_o     (mux_out)
   );

   stsel_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (mux_out),
      .bypass (bypass),
      .lvl_o  (trig_sel),
      .edge_o (trig_edge)
   );

   stsel_capture u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_edge (trig_edge),
      .armed     (cnt_armed),
      .waiting   (cnt_waiting),
      .ack       (ack),
      .irq_en    (irq_en_q),
      .valid_o   (trig_valid),
      .status_o  (status),
      .irq_o     (irq)
   );

   // R8
   valid_needs_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_valid |-> (cnt_armed && cnt_waiting));
   // R7
   code0_synced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q == '0) |-> !bypass);
endmodule

// File: tb/stsel_top_bench.sv
module stsel_top_bench;
   localparam int NEXT = 10;
   localparam int NBUS = 7;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            sw_pulse = 1'b0;
   logic [NEXT-1:0] ext_pin = '0;
   logic [NBUS-1:0] bus_trig = '0;
   logic            gp_cnt_out = 1'b0;
   logic            cfg_wr = 1'b0;
   logic [4:0]      cfg_sel = '0;
   logic            cfg_sync_en = 1'b0;
   logic            cfg_irq_en = 1'b0;
   logic            ack = 1'b0;
   logic            cnt_armed = 1'b0;
   logic            cnt_waiting = 1'b0;
   logic            trig_sel, trig_valid, status, irq;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   stsel_top u_stsel_top (
      .clk(clk), .rst_n(rst_n), .sw_pulse(sw_pulse), .ext_pin(ext_pin),
      .bus_trig(bus_trig), .gp_cnt_out(gp_cnt_out), .cfg_wr(cfg_wr),
      .cfg_sel(cfg_sel), .cfg_sync_en(cfg_sync_en), .cfg_irq_en(cfg_irq_en),
      .ack(ack), .cnt_armed(cnt_armed), .cnt_waiting(cnt_waiting),
      .trig_sel(trig_sel), .trig_valid(trig_valid), .status(status), .irq(irq)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // position 0 sw, 1..10 ext, 11..17 bus, 18 gp; -1 drives none
   task automatic drive_src(input int pos);
      sw_pulse   = (pos == 0);
      ext_pin    = '0;
      bus_trig   = '0;
      gp_cnt_out = (pos == 18);
      if (pos >= 1 && pos <= 10) ext_pin[pos-1] = 1'b1;
      if (pos >= 11 && pos <= 17) bus_trig[pos-11] = 1'b1;
   endtask

   task automatic cfg_write(input int sel, input logic sy, input logic ie);
      @(negedge clk);
      cfg_sel = 5'(sel); cfg_sync_en = sy; cfg_irq_en = ie; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic do_ack();
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
   endtask

   initial begin
      #400000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, all sources high yet trigger stays low
      sw_pulse = 1'b1; ext_pin = '1; bus_trig = '1; gp_cnt_out = 1'b1;
      repeat (4) @(negedge clk);
      #1;
      chk("R1 trig_sel", trig_sel, 1'b0);
      chk("R1 status", status, 1'b0);
      chk("R1 irq", irq, 1'b0);
      drive_src(-1);

      // R2/R3: sweep every code against every source, counter not waiting
      for (int code = 0; code < 32; code++) begin
         cfg_write(code, 1'b0, 1'b0);
         for (int pos = 0; pos < 19; pos++) begin
            @(negedge clk); drive_src(pos);
            repeat (3) @(negedge clk);
            #1;
            chk(code <= 18 ? "R2 mapping" : "R3 unused low", trig_sel,
                (code == pos) && (code <= 18));
         end
         @(negedge clk); drive_src(-1);
      end
      #1 chk("R8 no status while idle", status, 1'b0);

      // R5: synchronized path, ext pin 0
      cfg_write(1, 1'b1, 1'b0);
      @(negedge clk); cnt_armed = 1'b1; cnt_waiting = 1'b1;
      @(negedge clk); ext_pin[0] = 1'b1;
      #1 chk("R5 valid before edges", trig_valid, 1'b0);
      @(negedge clk); #1;
      chk("R5 trig_sel one edge", trig_sel, 1'b0);
      chk("R5 valid one edge", trig_valid, 1'b0);
      @(negedge clk); #1;
      chk("R5 trig_sel two edges", trig_sel, 1'b1);
      chk("R5 valid two edges", trig_valid, 1'b1);
      @(negedge clk); #1;
      chk("R5 valid single cycle", trig_valid, 1'b0);
      chk("R9 status set", status, 1'b1);
      chk("R12 irq masked", irq, 1'b0);
      cfg_write(1, 1'b1, 1'b1);
      #1 chk("R12 irq enabled", irq, 1'b1);
      do_ack();
      #1;
      chk("R10 ack clears", status, 1'b0);
      chk("R12 irq follows status", irq, 1'b0);
      repeat (3) @(negedge clk);
      #1 chk("R9 level not re-trigger", status, 1'b0);

      // R4: field changes without write strobe are ignored
      @(negedge clk); cfg_sel = 5'd2; ext_pin = 10'b10;
      repeat (4) @(negedge clk);
      #1 chk("R4 hold without write", trig_sel, 1'b0);
      @(negedge clk); ext_pin = '0;

      // R6: bypass path, ext pin 1
      cfg_write(2, 1'b0, 1'b1);
      @(negedge clk); ext_pin[1] = 1'b1;
      #1;
      chk("R6 trig_sel immediate", trig_sel, 1'b1);
      chk("R6 valid immediate", trig_valid, 1'b1);
      chk("R9 status not yet", status, 1'b0);
      @(negedge clk); #1;
      chk("R6 valid single cycle", trig_valid, 1'b0);
      chk("R9 status set bypass", status, 1'b1);
      chk("R12 irq set", irq, 1'b1);
      @(negedge clk); ext_pin[1] = 1'b0;
      @(negedge clk); #1;
      chk("R9 sticky after trigger drops", status, 1'b1);

      // R11: ack and valid same cycle
      do_ack();
      #1 chk("R10 ack clears bypass", status, 1'b0);
      @(negedge clk); ext_pin[1] = 1'b1; ack = 1'b1;
      @(negedge clk); ack = 1'b0; #1;
      chk("R11 set wins over ack", status, 1'b1);
      do_ack();
      @(negedge clk); ext_pin[1] = 1'b0;

      // R8: not armed or not waiting
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         cnt_armed = (k == 1); cnt_waiting = (k == 0);
         ext_pin[1] = 1'b1;
         #1 chk("R8 valid gated", trig_valid, 1'b0);
         @(negedge clk); ext_pin[1] = 1'b0;
         #1 chk("R8 status unchanged", status, 1'b0);
      end

      // R7: code 0 with sync field clear still synchronizes
      cfg_write(0, 1'b0, 1'b0);
      @(negedge clk); cnt_armed = 1'b1; cnt_waiting = 1'b1;
      @(negedge clk); sw_pulse = 1'b1;
      #1 chk("R7 no immediate valid", trig_valid, 1'b0);
      @(negedge clk); #1 chk("R7 no valid after one edge", trig_valid, 1'b0);
      @(negedge clk); #1 chk("R7 valid after two edges", trig_valid, 1'b1);
      @(negedge clk); #1 chk("R7 status", status, 1'b1);
      sw_pulse = 1'b0;

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule